// File: doc/BRIEF.md
# Subsystem power command register block

This block is the software-facing register file of a power controller that looks after 64 logical subsystems. Each subsystem owns a two-bit requested power state. The states are packed sixteen to a 32-bit configuration word. Writing a configuration word does not change the power state in use. The new states take effect only when software issues an apply command through the command register. The block then raises a busy flag for a programmable number of clock cycles. At the end of that time it copies every configuration word into the matching status word, and it drives the copied states on a flat output bus for the power switches.

A command runs at once, or it waits for an external trigger pulse before its busy period starts. Outcomes are reported through one interrupt register. That register holds an eight-bit cause code, an enable bit, a pending bit that software clears by writing one, and a software-raised interrupt flag. Two wake-enable words gate up to 64 wake sources. Sources that pass the gate are latched into sticky wake-status words, and each newly latched source raises a wake cause.

The host side is a single-cycle valid/write/address/data port. Read data comes back one cycle after the read request.

Top module: `pwr_cmd_regs`

## Requirements
- R1: After reset, every readable register reads zero, `irq` is low, `ss_state` is zero and `bus_rvalid` is low.
- R2: A read returns its data on `bus_rdata`, with `bus_rvalid` high, in the cycle after the request. The address map is:
  - status at 0x00, where bit 8 is busy;
  - command at 0x04, which reads zero;
  - interrupt at 0x08;
  - wake enable n at 0x10+4n and wake status n at 0x18+4n, for n = 0..1;
  - configuration n at 0x20+4n and subsystem status n at 0x30+4n, for n = 0..3.

  Configuration and wake-enable words read back what was written. Writes to subsystem status words, the status register and unmapped addresses change nothing, and unmapped reads return zero.
- R3: A command word holds the code in bits 7:0, the completion-interrupt request in bit 8 and the mode in bits 10:9. Mode 1 (immediate) with code 0x01 (apply), written while the block is idle, sets busy for exactly BUSY_CYCLES cycles. On the edge where busy clears, all configuration words are copied into the subsystem status words.
- R4: A command write while busy is high is ignored. The running command keeps its original end time and its data. Cause 2 is loaded and pending is set.
- R5: Mode 0 (no operation) changes no state and does not set busy.
- R6: Mode 2 (delayed) and mode 3 (triggered) set busy when written. The busy period of BUSY_CYCLES cycles starts only after a cycle with `trig_in` high. A pulse on `trig_in` while idle has no effect.
- R7: Any code other than 0x01 in a non-zero mode is rejected: cause 2, pending set, no busy.
- R8: A completed command that had bit 8 set loads cause 1 and sets pending. A completed command without bit 8 leaves cause and pending unchanged.
- R9: The interrupt register reads {sw flag at bit 10, pending at bit 9, enable at bit 8, cause at bits 7:0}. Bit 8 is read/write. `irq` is high exactly when enable and pending are both set.
- R10: Writing 1 to interrupt bit 9 clears pending and the sw flag. An event on the same edge wins, and pending stays set.
- R11: Writing 1 to interrupt bit 10 sets the sw flag and pending without changing the cause.
- R12: A `wake_src` bit k that is high while its enable bit is set latches bit k%32 of wake status word k/32. A latched bit is cleared by writing 1 to it. A newly latched bit loads cause 3 and sets pending. Disabled sources latch nothing.
- R13: Subsystem i drives `ss_state[2i+1:2i]`, which is bits 2(i%16)+1:2(i%16) of subsystem status word i/16.
- R14: When events coincide on one edge, the cause priority is command error (2) over completion (1) over wake (3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| trig_in | input | 1 | External start trigger for delayed and triggered modes |
| wake_src | input | 64 | Wake source levels, two words of 32 |
| irq | output | 1 | Interrupt request (enable AND pending) |
| ss_state | output | 128 | Applied power state, two bits per subsystem |

## Verification
A wrong busy counter shows up directly at the status register: polling it once per cycle after a command gives a busy count other than BUSY_CYCLES. The same polling reveals an early or late copy to the subsystem status words, off by as many cycles as the counter is off. A mispacked or miscopied configuration bit appears on one `ss_state` field on the completing edge. A sweep of four field patterns over all 64 subsystems touches every field with every value. Faults in the cause priority or in the pending logic are made visible by forcing events to coincide on one edge: an error with a wake, a completion with a wake, and a completion with a pending clear. The result is then read from the interrupt register in the next cycles.

// File: rtl/pwr_cmd_pkg.sv
package pwr_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_NOP = 2'd0,
    MODE_NOW = 2'd1,
    MODE_DLY = 2'd2,
    MODE_TRG = 2'd3
  } cmd_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

  // register offsets
  localparam logic [7:0] OFS_STAT = 8'h00;
  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_IRQ  = 8'h08;
  localparam logic [7:0] OFS_WKEN = 8'h10;
  localparam logic [7:0] OFS_WKST = 8'h18;
  localparam logic [7:0] OFS_CFG  = 8'h20;
  localparam logic [7:0] OFS_SSST = 8'h30;

  // bit positions
  localparam int unsigned BIT_BUSY  = 8;
  localparam int unsigned CMD_IOC   = 8;
  localparam int unsigned CMD_MODE  = 9;
  localparam int unsigned IRQ_EN    = 8;
  localparam int unsigned IRQ_PEND  = 9;
  localparam int unsigned IRQ_SW    = 10;

  localparam logic [7:0] CODE_APPLY   = 8'h01;
  localparam logic [7:0] CAUSE_DONE   = 8'd1;
  localparam logic [7:0] CAUSE_CMDERR = 8'd2;
  localparam logic [7:0] CAUSE_WAKE   = 8'd3;

endpackage

// File: rtl/pcr_cmd_seq.sv
module pcr_cmd_seq
  import pwr_cmd_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_code,
  input  logic       cmd_ioc,
  input  cmd_mode_e  cmd_mode,
  input  logic       trig_in,
  output logic       busy,
  output logic       done,
  output logic       done_ioc,
  output logic       err
);

  localparam int unsigned CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ioc_q;
  logic             code_ok;
  logic             accept;

  assign code_ok  = (cmd_code == CODE_APPLY);
  assign busy     = (state_q != SEQ_IDLE);
  assign accept   = cmd_wr && !busy && (cmd_mode != MODE_NOP) && code_ok;
  assign err      = cmd_wr && (busy || ((cmd_mode != MODE_NOP) && !code_ok));
  assign done     = (state_q == SEQ_RUN) && (cnt_q == '0);
  assign done_ioc = done && ioc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      ioc_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            ioc_q <= cmd_ioc;
            if (cmd_mode == MODE_NOW) begin
              state_q <= SEQ_RUN;
              cnt_q   <= CNT_LOAD;
            end else begin
              state_q <= SEQ_WAIT;
            end
          end
        end
        SEQ_WAIT: begin
          if (trig_in) begin
            state_q <= SEQ_RUN;
            cnt_q   <= CNT_LOAD;
          end
        end
        SEQ_RUN: begin
          if (cnt_q == '0) state_q <= SEQ_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R5: no-operation mode never starts a busy period
  a_r5_nop_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy && cmd_mode == MODE_NOP) |=> !busy)
    else $error("a_r5_nop_idle");

  // R6: waiting command holds until the trigger
  a_r6_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_WAIT && !trig_in) |=> (state_q == SEQ_WAIT))
    else $error("a_r6_wait_hold");

  // R7: rejected code leaves the block idle
  a_r7_bad_code_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy && cmd_mode != MODE_NOP && !code_ok) |=> !busy)
    else $error("a_r7_bad_code_idle");

  // R3: completion ends the busy period
  a_r3_done_clears: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy)
    else $error("a_r3_done_clears");

endmodule

// File: rtl/pcr_irq.sv
module pcr_irq
  import pwr_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic       ctl_en,
  input  logic       ctl_clr,
  input  logic       ctl_sw,
  input  logic       ev_err,
  input  logic       ev_done,
  input  logic       ev_wake,
  output logic [7:0] cause,
  output logic       irq_en,
  output logic       irq_pend,
  output logic       irq_sw,
  output logic       irq
);

  logic sw_set;
  logic any_set;

  assign sw_set  = ctl_wr && ctl_sw;
  assign any_set = ev_err || ev_done || ev_wake || sw_set;
  assign irq     = irq_en && irq_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause    <= '0;
      irq_en   <= 1'b0;
      irq_pend <= 1'b0;
      irq_sw   <= 1'b0;
    end else begin
      if (ctl_wr) irq_en <= ctl_en;

      if (ev_err)       cause <= CAUSE_CMDERR;
      else if (ev_done) cause <= CAUSE_DONE;
      else if (ev_wake) cause <= CAUSE_WAKE;

      if (any_set)                irq_pend <= 1'b1;
      else if (ctl_wr && ctl_clr) irq_pend <= 1'b0;

      if (sw_set)                 irq_sw <= 1'b1;
      else if (ctl_wr && ctl_clr) irq_sw <= 1'b0;
    end
  end

  // R4: a command error is visible as cause 2 with pending
  a_r4_err_cause: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> (cause == CAUSE_CMDERR && irq_pend))
    else $error("a_r4_err_cause");

  // R10: clear without a competing event drops pending and sw flag
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_clr && !any_set) |=> (!irq_pend && !irq_sw))
    else $error("a_r10_clear");

  // R14: completion outranks a wake event
  a_r14_done_over_wake: assert property (@(posedge clk) disable iff (rst)
    (ev_done && ev_wake && !ev_err) |=> (cause == CAUSE_DONE))
    else $error("a_r14_done_over_wake");

endmodule

// File: rtl/pcr_wake.sv
module pcr_wake #(
  parameter int unsigned WAKE_WORDS = 2,
  parameter int unsigned WORD_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [WAKE_WORDS-1:0]        en_wr,
  input  logic [WAKE_WORDS-1:0]        st_wr,
  input  logic [WORD_W-1:0]            wdata,
  input  logic [WAKE_WORDS*WORD_W-1:0] wake_src,
  output logic [WAKE_WORDS*WORD_W-1:0] en_flat,
  output logic [WAKE_WORDS*WORD_W-1:0] st_flat,
  output logic                         new_ev
);

  logic [WAKE_WORDS-1:0] fresh;

  for (genvar w = 0; w < WAKE_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] en_q;
    logic [WORD_W-1:0] st_q;
    logic [WORD_W-1:0] hit;

    assign hit = wake_src[w*WORD_W +: WORD_W] & en_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q <= '0;
        st_q <= '0;
      end else begin
        if (en_wr[w]) en_q <= wdata;
        st_q <= (st_q & ~(st_wr[w] ? wdata : '0)) | hit;
      end
    end

    assign fresh[w] = |(hit & ~st_q);
    assign en_flat[w*WORD_W +: WORD_W] = en_q;
    assign st_flat[w*WORD_W +: WORD_W] = st_q;
  end

  assign new_ev = |fresh;

  // R12: gated-off sources never add status bits
  a_r12_masked: assert property (@(posedge clk) disable iff (rst)
    !(|(wake_src & en_flat)) |=> ((st_flat & ~$past(st_flat)) == '0))
    else $error("a_r12_masked");

endmodule

// File: rtl/pwr_cmd_regs.sv
module pwr_cmd_regs
  import pwr_cmd_pkg::*;
#(
  parameter int unsigned NUM_SS      = 64,
  parameter int unsigned PWR_BITS    = 2,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned WAKE_WORDS  = 2,
  parameter int unsigned BUSY_CYCLES = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic [7:0]                   bus_addr,
  input  logic [WORD_W-1:0]            bus_wdata,
  output logic [WORD_W-1:0]            bus_rdata,
  output logic                         bus_rvalid,
  input  logic                         trig_in,
  input  logic [WAKE_WORDS*WORD_W-1:0] wake_src,
  output logic                         irq,
  output logic [NUM_SS*PWR_BITS-1:0]   ss_state
);

  localparam int unsigned CFG_WORDS = (NUM_SS * PWR_BITS) / WORD_W;
  localparam int unsigned CFG_BITS  = CFG_WORDS * WORD_W;
  localparam int unsigned WK_BITS   = WAKE_WORDS * WORD_W;

  logic wr_req;
  logic rd_req;
  assign wr_req = bus_valid && bus_write;
  assign rd_req = bus_valid && !bus_write;

  // address decode
  logic [CFG_WORDS-1:0]  cfg_hit;
  logic [CFG_WORDS-1:0]  ssst_hit;
  logic [WAKE_WORDS-1:0] wken_hit;
  logic [WAKE_WORDS-1:0] wkst_hit;

  for (genvar g = 0; g < CFG_WORDS; g++) begin : g_cfg_dec
    assign cfg_hit[g]  = (bus_addr == OFS_CFG  + 8'(4 * g));
    assign ssst_hit[g] = (bus_addr == OFS_SSST + 8'(4 * g));
  end
  for (genvar g = 0; g < WAKE_WORDS; g++) begin : g_wk_dec
    assign wken_hit[g] = (bus_addr == OFS_WKEN + 8'(4 * g));
    assign wkst_hit[g] = (bus_addr == OFS_WKST + 8'(4 * g));
  end

  logic cmd_wr;
  logic ctl_wr;
  assign cmd_wr = wr_req && (bus_addr == OFS_CMD);
  assign ctl_wr = wr_req && (bus_addr == OFS_IRQ);

  // command sequencer
  logic busy;
  logic done;
  logic done_ioc;
  logic cmd_err;

  pcr_cmd_seq #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .cmd_code (bus_wdata[7:0]),
    .cmd_ioc  (bus_wdata[CMD_IOC]),
    .cmd_mode (cmd_mode_e'(bus_wdata[CMD_MODE +: 2])),
    .trig_in  (trig_in),
    .busy     (busy),
    .done     (done),
    .done_ioc (done_ioc),
    .err      (cmd_err)
  );

  // configuration and applied status words
  logic [CFG_BITS-1:0] cfg_flat;
  logic [CFG_BITS-1:0] stat_flat;

  for (genvar g = 0; g < CFG_WORDS; g++) begin : g_words
    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] stat_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q  <= '0;
        stat_q <= '0;
      end else begin
        if (wr_req && cfg_hit[g]) cfg_q  <= bus_wdata;
        if (done)                 stat_q <= cfg_q;
      end
    end

    assign cfg_flat[g*WORD_W +: WORD_W]  = cfg_q;
    assign stat_flat[g*WORD_W +: WORD_W] = stat_q;
  end

  assign ss_state = stat_flat[NUM_SS*PWR_BITS-1:0];

  // wake gating
  logic [WK_BITS-1:0] wken_flat;
  logic [WK_BITS-1:0] wkst_flat;
  logic               wake_ev;

  pcr_wake #(
    .WAKE_WORDS (WAKE_WORDS),
    .WORD_W     (WORD_W)
  ) u_wake (
    .clk      (clk),
    .rst      (rst),
    .en_wr    (wken_hit & {WAKE_WORDS{wr_req}}),
    .st_wr    (wkst_hit & {WAKE_WORDS{wr_req}}),
    .wdata    (bus_wdata),
    .wake_src (wake_src),
    .en_flat  (wken_flat),
    .st_flat  (wkst_flat),
    .new_ev   (wake_ev)
  );

  // interrupt cause
  logic [7:0] irq_cause;
  logic       irq_en;
  logic       irq_pend;
  logic       irq_sw;

  pcr_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_en   (bus_wdata[IRQ_EN]),
    .ctl_clr  (bus_wdata[IRQ_PEND]),
    .ctl_sw   (bus_wdata[IRQ_SW]),
    .ev_err   (cmd_err),
    .ev_done  (done_ioc),
    .ev_wake  (wake_ev),
    .cause    (irq_cause),
    .irq_en   (irq_en),
    .irq_pend (irq_pend),
    .irq_sw   (irq_sw),
    .irq      (irq)
  );

  // read path
  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_STAT) rd_mux[BIT_BUSY] = busy;
    if (bus_addr == OFS_IRQ)  rd_mux[10:0] = {irq_sw, irq_pend, irq_en, irq_cause};
    for (int g = 0; g < CFG_WORDS; g++) begin
      if (cfg_hit[g])  rd_mux = cfg_flat[g*WORD_W +: WORD_W];
      if (ssst_hit[g]) rd_mux = stat_flat[g*WORD_W +: WORD_W];
    end
    for (int g = 0; g < WAKE_WORDS; g++) begin
      if (wken_hit[g]) rd_mux = wken_flat[g*WORD_W +: WORD_W];
      if (wkst_hit[g]) rd_mux = wkst_flat[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end

  // R3: the applied states equal the configuration seen before busy fell
  a_r3_copy_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (stat_flat == $past(cfg_flat)))
    else $error("a_r3_copy_on_done");

  // R13: applied states move only on completion
  a_r13_stat_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(stat_flat))
    else $error("a_r13_stat_hold");

  // R2: every read request is answered next cycle
  a_r2_rvalid: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid)
    else $error("a_r2_rvalid");

endmodule

// File: tb/sim_pwr_cmd_regs.sv
`timescale 1ns/1ps
module sim_pwr_cmd_regs;

  localparam int B = 5;
  localparam logic [7:0] A_STAT = 8'h00, A_CMD = 8'h04, A_ICR = 8'h08;
  localparam logic [7:0] A_WKEN = 8'h10, A_WKST = 8'h18, A_CFG = 8'h20, A_SSST = 8'h30;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_valid = 1'b0;
  logic         bus_write = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic         trig_in = 1'b0;
  logic [63:0]  wake_src = '0;
  logic         irq;
  logic [127:0] ss_state;

  int checks = 0;
  int fails  = 0;
  logic last_rv;
  logic [127:0] exp_cfg = '0;
  logic [127:0] exp_ss  = '0;

  always #10 clk = ~clk;

  pwr_cmd_regs #(.BUSY_CYCLES(B)) u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .trig_in(trig_in), .wake_src(wake_src),
    .irq(irq), .ss_state(ss_state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; last_rv = bus_rvalid;
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wr_cfg(input int w, input logic [31:0] d);
    bus_wr(A_CFG + 8'(4 * w), d);
    exp_cfg[w*32 +: 32] = d;
  endtask

  task automatic count_busy(output int n);
    logic [31:0] d;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      bus_rd(A_STAT, d);
      if (!d[8]) break;
      n++;
    end
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
  endtask

  task automatic pulse_wake(input logic [63:0] v);
    wake_src = v; @(negedge clk); wake_src = '0;
  endtask

  function automatic logic [1:0] fld(int i, int t);
    return 2'((i * 5 + t * 3 + i / 7) & 3);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
    chk("R1 ss_state", {31'b0, |ss_state}, 32'h0);
    rd_chk("R1 status", A_STAT, 32'h0);
    rd_chk("R1 icr", A_ICR, 32'h0);
    for (int w = 0; w < 2; w++) begin
      rd_chk("R1 wken", A_WKEN + 8'(4 * w), 32'h0);
      rd_chk("R1 wkst", A_WKST + 8'(4 * w), 32'h0);
    end
    for (int w = 0; w < 4; w++) begin
      rd_chk("R1 cfg", A_CFG + 8'(4 * w), 32'h0);
      rd_chk("R1 ssst", A_SSST + 8'(4 * w), 32'h0);
    end

    // R2 map, readback, ignored writes
    for (int w = 0; w < 4; w++) wr_cfg(w, 32'hC0DE_0000 + 32'(w * 17));
    for (int w = 0; w < 4; w++) rd_chk("R2 cfg readback", A_CFG + 8'(4 * w), 32'hC0DE_0000 + 32'(w * 17));
    chk("R2 rvalid", {31'b0, last_rv}, 32'h1);
    bus_wr(A_SSST, 32'hDEAD_BEEF);
    rd_chk("R2 ssst not writable", A_SSST, 32'h0);
    bus_wr(8'h44, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped read", 8'h44, 32'h0);
    rd_chk("R2 cmd reads zero", A_CMD, 32'h0);
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    rd_chk("R2 status not writable", A_STAT, 32'h0);

    // R3 / R13 sweep over all subsystems
    for (int t = 0; t < 4; t++) begin
      logic [127:0] pat;
      for (int i = 0; i < 64; i++) pat[2*i +: 2] = fld(i, t);
      for (int w = 0; w < 4; w++) wr_cfg(w, pat[w*32 +: 32]);
      chk("R3 ss before apply", ss_state[31:0], exp_ss[31:0]);
      bus_wr(A_CMD, 32'h0000_0201);
      count_busy(n);
      chk("R3 busy length", 32'(n), 32'(B));
      exp_ss = exp_cfg;
      for (int w = 0; w < 4; w++) rd_chk("R3 ssst word", A_SSST + 8'(4 * w), pat[w*32 +: 32]);
      for (int i = 0; i < 64; i++) chk("R13 field", {30'b0, ss_state[2*i +: 2]}, {30'b0, fld(i, t)});
    end
    rd_chk("R8 no ioc leaves icr", A_ICR, 32'h0);

    // R5 no-operation
    wr_cfg(0, 32'h1234_5678);
    bus_wr(A_CMD, 32'h0000_0001);
    rd_chk("R5 nop no busy", A_STAT, 32'h0);
    chk("R5 nop ss unchanged", ss_state[31:0], exp_ss[31:0]);
    rd_chk("R5 nop icr", A_ICR, 32'h0);

    // R7 bad code
    bus_wr(A_CMD, 32'h0000_0205);
    rd_chk("R7 bad code icr", A_ICR, 32'h0000_0202);
    rd_chk("R7 bad code no busy", A_STAT, 32'h0);
    bus_wr(A_ICR, 32'h0000_0200);
    rd_chk("R10 clear pending", A_ICR, 32'h0000_0002);

    // R8 / R9 completion interrupt
    bus_wr(A_CMD, 32'h0000_0301);
    count_busy(n);
    chk("R8 busy length", 32'(n), 32'(B));
    exp_ss = exp_cfg;
    rd_chk("R8 ioc cause", A_ICR, 32'h0000_0201);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    rd_chk("R8 applied word", A_SSST, 32'h1234_5678);
    bus_wr(A_ICR, 32'h0000_0100);
    chk("R9 irq enabled", {31'b0, irq}, 32'h1);
    rd_chk("R9 enable readback", A_ICR, 32'h0000_0301);
    bus_wr(A_ICR, 32'h0000_0300);
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);
    rd_chk("R10 icr after clear", A_ICR, 32'h0000_0101);

    // R4 command while busy
    wr_cfg(0, 32'hAAAA_0000);
    bus_wr(A_CMD, 32'h0000_0201);
    bus_wr(A_CMD, 32'h0000_0301);
    count_busy(n);
    chk("R4 end time kept", 32'(n), 32'(B - 1));
    exp_ss = exp_cfg;
    rd_chk("R4 data applied", A_SSST, 32'hAAAA_0000);
    rd_chk("R4 err cause", A_ICR, 32'h0000_0302);
    chk("R4 irq", {31'b0, irq}, 32'h1);
    bus_wr(A_ICR, 32'h0000_0300);
    rd_chk("R4 cleared", A_ICR, 32'h0000_0102);

    // R6 delayed mode
    wr_cfg(0, 32'h0F0F_0F0F);
    bus_wr(A_CMD, 32'h0000_0401);
    count_busy(n);
    n = 0;
    for (int k = 0; k < 8; k++) begin
      bus_rd(A_STAT, d);
      if (d[8]) n++;
    end
    chk("R6 delayed waits", 32'(n), 32'd8);
    chk("R6 no early apply", ss_state[31:0], exp_ss[31:0]);
    pulse_trig();
    count_busy(n);
    chk("R6 delayed busy length", 32'(n), 32'(B));
    exp_ss = exp_cfg;
    rd_chk("R6 delayed applied", A_SSST, 32'h0F0F_0F0F);

    // R6 triggered mode with completion interrupt
    wr_cfg(0, 32'hF0F0_F0F0);
    bus_wr(A_CMD, 32'h0000_0701);
    repeat (3) @(negedge clk);
    rd_chk("R6 triggered waits", A_STAT, 32'h0000_0100);
    pulse_trig();
    count_busy(n);
    chk("R6 triggered busy length", 32'(n), 32'(B));
    exp_ss = exp_cfg;
    chk("R6 triggered applied", ss_state[31:0], 32'hF0F0_F0F0);
    rd_chk("R6 triggered cause", A_ICR, 32'h0000_0301);
    bus_wr(A_ICR, 32'h0000_0300);

    // R6 trigger while idle
    wr_cfg(0, 32'h0000_0003);
    pulse_trig();
    rd_chk("R6 idle trigger no busy", A_STAT, 32'h0);
    chk("R6 idle trigger no apply", ss_state[31:0], exp_ss[31:0]);

    // R10 clear on completion edge
    bus_wr(A_CMD, 32'h0000_0301);
    repeat (B - 1) @(negedge clk);
    bus_wr(A_ICR, 32'h0000_0300);
    exp_ss = exp_cfg;
    rd_chk("R10 event wins clear", A_ICR, 32'h0000_0301);
    rd_chk("R10 idle after", A_STAT, 32'h0);
    chk("R10 applied", ss_state[31:0], 32'h0000_0003);
    bus_wr(A_ICR, 32'h0000_0300);

    // R11 software interrupt
    bus_wr(A_ICR, 32'h0000_0500);
    rd_chk("R11 sw set", A_ICR, 32'h0000_0701);
    chk("R11 irq", {31'b0, irq}, 32'h1);
    bus_wr(A_ICR, 32'h0000_0300);
    rd_chk("R11 sw cleared", A_ICR, 32'h0000_0101);
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    // R12 wake gating
    bus_wr(A_WKEN, 32'h0000_00F0);
    bus_wr(A_WKEN + 8'h4, 32'h0000_0001);
    rd_chk("R12 wken0", A_WKEN, 32'h0000_00F0);
    rd_chk("R12 wken1", A_WKEN + 8'h4, 32'h0000_0001);
    pulse_wake(64'h1);
    rd_chk("R12 masked source", A_WKST, 32'h0);
    rd_chk("R12 masked no event", A_ICR, 32'h0000_0101);
    pulse_wake(64'h10);
    rd_chk("R12 latched", A_WKST, 32'h0000_0010);
    rd_chk("R12 wake cause", A_ICR, 32'h0000_0303);
    pulse_wake(64'h1_0000_0000);
    rd_chk("R12 word1 latched", A_WKST + 8'h4, 32'h0000_0001);
    bus_wr(A_WKST, 32'h0000_0010);
    rd_chk("R12 w1c", A_WKST, 32'h0);
    bus_wr(A_WKST + 8'h4, 32'h0000_0001);
    rd_chk("R12 w1c word1", A_WKST + 8'h4, 32'h0);
    bus_wr(A_ICR, 32'h0000_0300);

    // R14 error beats wake
    bus_wr(A_CMD, 32'h0000_0201);
    wake_src = 64'h20;
    bus_wr(A_CMD, 32'h0000_0201);
    wake_src = '0;
    count_busy(n);
    rd_chk("R14 error over wake", A_ICR, 32'h0000_0302);
    bus_wr(A_ICR, 32'h0000_0300);

    // R14 completion beats wake
    bus_wr(A_CMD, 32'h0000_0301);
    repeat (B - 1) @(negedge clk);
    pulse_wake(64'h40);
    rd_chk("R14 done over wake", A_ICR, 32'h0000_0301);
    rd_chk("R14 both wakes latched", A_WKST, 32'h0000_0060);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule